// File: doc/BRIEF.md
# TDC Control Word and Coarse Timebase

This block holds the 32-bit basic-control word of a time-to-digital converter and runs the timing logic that word steers. Software loads the word through a single-cycle write port and can read it back at any time. From the word the block derives the operating-mode flags: triggered or trigger-less acquisition, and extended debug output. It also drives a level that holds the converter's statistics counters cleared, and the exponent of a calibration-pulse divider.

A free-running 11-bit coarse counter advances once per system clock, which is 200 MHz in the target design, so one tick is 5 ns. Software cannot clear this counter directly. Writing the reset-request bit only arms a request. The counter is zeroed at the next valid trigger edge, so many converters that share one trigger line restart their coarse time together. A calibration generator first divides the system clock by 125 to get a 1.6 MHz base. It then divides that base by a further 2^n and emits a one-cycle hit strobe at the resulting rate.

Top module: `tdc_ctrl_timebase`

## Requirements
- R1: While reset is asserted and directly after it, the read-back word is 0, all flags and the calibration strobe are low, and the coarse counter holds 0.
- R2: Bits 31-28, 12, 8, 4 and 3-0 read back as last written. Bits 27-14, 11-9 and 7-5 always read as 0.
- R3: With no clear pending, the coarse counter adds 1 on every clock and wraps from 2047 to 0.
- R4: A write with bit 13 set arms a coarse reset. Read-back bit 13 shows 1 while the request is armed. Arming leaves the counter running. A write with bit 13 clear does not disarm a pending request.
- R5: A rising edge on the trigger input while a reset is armed zeroes the coarse counter on that clock edge and disarms the request, so read-back bit 13 returns to 0.
- R6: A trigger edge with no armed request does not disturb the counter.
- R7: Only a low-to-high transition of the trigger counts. A trigger held high does not consume a request that is armed later.
- R8: A trigger edge that occurs while bit 8 is set is not valid. It leaves the counter running and the request armed.
- R9: The statistics-clear output follows bit 8, the debug flag follows bit 4, and the trigger-less flag follows bit 12. Each takes the new value on the clock after the write.
- R10: The calibration strobe is a single-cycle pulse whose period is 125·2^n clocks, where n is bits 31-28.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to load |
| rd_data | output | 32 | Control word read-back, with the armed-reset flag in bit 13 |
| trig_in | input | 1 | Trigger input, sampled for rising edges |
| coarse_cnt | output | 11 | Coarse time counter |
| cal_hit | output | 1 | Calibration hit strobe |
| trigless_mode | output | 1 | 1 selects trigger-less operation |
| debug_mode | output | 1 | Debug-word output enable |
| stat_clear | output | 1 | Holds the statistics counters cleared |

## Verification
A lost or stuck arm flag appears on read-back bit 13 one clock after the write or the trigger. A wrong edge detector or a wrong trigger qualifier shows as a coarse counter that does not read 0 on the first sample after a qualifying trigger edge, or one that drops to 0 when no edge should qualify. A miscounting prescaler or divider appears only at the next strobe, up to 125·2^n clocks later, so the periods are measured between consecutive strobes for several exponents.

// File: rtl/tdc_ctrl_pkg.sv
package tdc_ctrl_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned EXP_W     = 4;
  localparam int unsigned EXP_LSB   = 28;
  localparam int unsigned ARM_BIT   = 13;
  localparam int unsigned MODE_BIT  = 12;
  localparam int unsigned CLR_BIT   = 8;
  localparam int unsigned DBG_BIT   = 4;
  localparam int unsigned PROBE_W   = 4;

  // bits held in the control register (arm flag lives separately)
  function automatic logic [WORD_W-1:0] keep_mask();
    logic [WORD_W-1:0] m;
    m = '0;
    for (int i = 0; i < int'(EXP_W); i++) m[EXP_LSB+i] = 1'b1;
    for (int i = 0; i < int'(PROBE_W); i++) m[i] = 1'b1;
    m[MODE_BIT] = 1'b1;
    m[CLR_BIT]  = 1'b1;
    m[DBG_BIT]  = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/tdc_rst_sync.sv
module tdc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/tdc_ctrl_reg.sv
module tdc_ctrl_reg
  import tdc_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              consume,
  output logic [WORD_W-1:0] ctrl_word,
  output logic              arm_pending
);
  localparam logic [WORD_W-1:0] KEEP = keep_mask();

  logic [WORD_W-1:0] word_q, word_d;
  logic              arm_q, arm_d;
  logic              word_en;

  assign word_en = wr_en;

  always_comb begin
    word_d = wr_data & KEEP;
    arm_d  = (arm_q & ~consume) | (wr_en & wr_data[ARM_BIT]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      arm_q  <= 1'b0;
    end else begin
      if (word_en) word_q <= word_d;
      arm_q <= arm_d;
    end
  end

  assign ctrl_word   = word_q;
  assign arm_pending = arm_q;
endmodule

// File: rtl/tdc_coarse_timebase.sv
module tdc_coarse_timebase #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_in,
  input  logic             trig_block,
  input  logic             arm_pending,
  output logic             consume,
  output logic [CNT_W-1:0] count
);
  logic             trig_q;
  logic             trig_rise;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    trig_rise = trig_in & ~trig_q & ~trig_block;
    consume   = trig_rise & arm_pending;
    cnt_d     = consume ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      trig_q <= trig_in;
      cnt_q  <= cnt_d;
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/tdc_cal_pulse.sv
module tdc_cal_pulse #(
  parameter int unsigned PRESCALE = 125,
  parameter int unsigned EXP_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EXP_W-1:0] exponent,
  output logic             hit
);
  localparam int unsigned PRE_W = $clog2(PRESCALE);
  localparam int unsigned DIV_W = (1 << EXP_W) - 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [DIV_W-1:0] div_q, div_d, mask;
  logic             base_tick;
  logic             hit_q, hit_d;

  always_comb begin
    for (int i = 0; i < int'(DIV_W); i++) mask[i] = (i < int'(exponent));
  end

  always_comb begin
    base_tick = (pre_q == PRE_LAST);
    pre_d     = base_tick ? '0 : pre_q + 1'b1;
    div_d     = div_q + 1'b1;
    hit_d     = base_tick && ((div_q & mask) == mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      div_q <= '0;
      hit_q <= 1'b0;
    end else begin
      pre_q <= pre_d;
      if (base_tick) div_q <= div_d;
      hit_q <= hit_d;
    end
  end

  assign hit = hit_q;
endmodule

// File: rtl/tdc_ctrl_timebase.sv
module tdc_ctrl_timebase
  import tdc_ctrl_pkg::*;
#(
  parameter int unsigned COARSE_W = 11,
  parameter int unsigned PRESCALE = 125
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [WORD_W-1:0]   wr_data,
  output logic [WORD_W-1:0]   rd_data,
  input  logic                trig_in,
  output logic [COARSE_W-1:0] coarse_cnt,
  output logic                cal_hit,
  output logic                trigless_mode,
  output logic                debug_mode,
  output logic                stat_clear
);
  logic              srst_n;
  logic [WORD_W-1:0] ctrl_word;
  logic              arm_pending;
  logic              coarse_clr;

  tdc_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  tdc_ctrl_reg u_reg (
    .clk         (clk),
    .rst_n       (srst_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .consume     (coarse_clr),
    .ctrl_word   (ctrl_word),
    .arm_pending (arm_pending)
  );

  tdc_coarse_timebase #(.CNT_W(COARSE_W)) u_tb (
    .clk         (clk),
    .rst_n       (srst_n),
    .trig_in     (trig_in),
    .trig_block  (ctrl_word[CLR_BIT]),
    .arm_pending (arm_pending),
    .consume     (coarse_clr),
    .count       (coarse_cnt)
  );

  tdc_cal_pulse #(.PRESCALE(PRESCALE), .EXP_W(EXP_W)) u_cal (
    .clk      (clk),
    .rst_n    (srst_n),
    .exponent (ctrl_word[EXP_LSB +: EXP_W]),
    .hit      (cal_hit)
  );

  always_comb begin
    rd_data          = ctrl_word;
    rd_data[ARM_BIT] = arm_pending;
  end

  assign trigless_mode = ctrl_word[MODE_BIT];
  assign debug_mode    = ctrl_word[DBG_BIT];
  assign stat_clear    = ctrl_word[CLR_BIT];
endmodule

// File: rtl/tdc_ctrl_timebase_chk.sv
module tdc_ctrl_timebase_chk
  import tdc_ctrl_pkg::*;
#(
  parameter int unsigned COARSE_W = 11
) (
  input logic                clk,
  input logic                srst_n,
  input logic                wr_en,
  input logic [WORD_W-1:0]   wr_data,
  input logic [COARSE_W-1:0] coarse_cnt,
  input logic                coarse_clr,
  input logic                arm_pending,
  input logic                cal_hit,
  input logic                stat_clear,
  input logic [WORD_W-1:0]   rd_data
);
  assert_count_step_R3: assert property (@(posedge clk) disable iff (!srst_n)
    !coarse_clr |=> coarse_cnt == COARSE_W'($past(coarse_cnt) + 1'b1));

  assert_arm_set_R4: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_en && wr_data[ARM_BIT]) |=> arm_pending);

  assert_clear_disarm_R5: assert property (@(posedge clk) disable iff (!srst_n)
    (coarse_clr && !(wr_en && wr_data[ARM_BIT])) |=> (coarse_cnt == '0 && !arm_pending));

  assert_clear_needs_arm_R6: assert property (@(posedge clk) disable iff (!srst_n)
    coarse_clr |-> arm_pending);

  assert_blocked_trig_R8: assert property (@(posedge clk) disable iff (!srst_n)
    stat_clear |-> !coarse_clr);

  assert_clr_follow_R9: assert property (@(posedge clk) disable iff (!srst_n)
    wr_en |=> stat_clear == $past(wr_data[CLR_BIT]));

  assert_hit_single_R10: assert property (@(posedge clk) disable iff (!srst_n)
    cal_hit |=> !cal_hit);

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!srst_n)
    rd_data[27:14] == '0 && rd_data[11:9] == '0 && rd_data[7:5] == '0);
endmodule

bind tdc_ctrl_timebase tdc_ctrl_timebase_chk #(.COARSE_W(COARSE_W)) u_chk (
  .clk         (clk),
  .srst_n      (srst_n),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .coarse_cnt  (coarse_cnt),
  .coarse_clr  (coarse_clr),
  .arm_pending (arm_pending),
  .cal_hit     (cal_hit),
  .stat_clear  (stat_clear),
  .rd_data     (rd_data)
);

// File: tb/tb_tdc_ctrl_timebase.sv
module tb_tdc_ctrl_timebase;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        trig_in;
  logic [10:0] coarse_cnt;
  logic        cal_hit;
  logic        trigless_mode;
  logic        debug_mode;
  logic        stat_clear;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  tdc_ctrl_timebase dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .trig_in(trig_in), .coarse_cnt(coarse_cnt),
    .cal_hit(cal_hit), .trigless_mode(trigless_mode),
    .debug_mode(debug_mode), .stat_clear(stat_clear)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_word(input logic [31:0] w);
    @(negedge clk);
    wr_en = 1; wr_data = w;
    @(negedge clk);
    wr_en = 0; wr_data = '0;
  endtask

  task automatic t_reset();
    rst_n = 0; wr_en = 0; wr_data = '0; trig_in = 0;
    repeat (3) @(negedge clk);
    check(rd_data == 0, "R1 readback", rd_data, 0);
    check(coarse_cnt == 0, "R1 coarse", coarse_cnt, 0);
    check({cal_hit, trigless_mode, debug_mode, stat_clear} == 0, "R1 flags",
          {cal_hit, trigless_mode, debug_mode, stat_clear}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(rd_data == 0, "R1 readback after release", rd_data, 0);
  endtask

  task automatic t_readback();
    write_word(32'hFFFF_DFFF);
    check(rd_data == 32'hF000_111F, "R2 all ones", rd_data, 32'hF000_111F);
    write_word(32'h5000_0005);
    check(rd_data == 32'h5000_0005, "R2 pattern", rd_data, 32'h5000_0005);
    write_word(32'h0);
  endtask

  task automatic t_count();
    logic [10:0] c0;
    int guard;
    @(negedge clk); c0 = coarse_cnt;
    @(negedge clk);
    check(coarse_cnt == 11'(c0 + 1), "R3 step", coarse_cnt, 11'(c0 + 1));
    guard = 0;
    while (coarse_cnt != 11'h7FF && guard < 3000) begin @(negedge clk); guard++; end
    @(negedge clk);
    check(coarse_cnt == 0, "R3 wrap", coarse_cnt, 0);
  endtask

  task automatic t_flags();
    write_word(32'h0000_1110);
    check(stat_clear && debug_mode && trigless_mode, "R9 flags set",
          {trigless_mode, debug_mode, stat_clear}, 3'b111);
    write_word(32'h0000_0010);
    check(!stat_clear && debug_mode && !trigless_mode, "R9 flags mixed",
          {trigless_mode, debug_mode, stat_clear}, 3'b010);
    write_word(32'h0);
  endtask

  task automatic t_arm_and_trigger();
    logic [10:0] c0;
    // R6: edge without an armed request
    @(negedge clk); c0 = coarse_cnt; trig_in = 1;
    @(negedge clk);
    check(coarse_cnt == 11'(c0 + 1), "R6 unarmed edge", coarse_cnt, 11'(c0 + 1));
    // R7: arm while trigger held high
    write_word(32'h0000_2000);
    check(rd_data[13] == 1, "R4 armed flag", rd_data[13], 1);
    @(negedge clk); c0 = coarse_cnt;
    repeat (4) @(negedge clk);
    check(coarse_cnt == 11'(c0 + 4), "R7 held high no clear", coarse_cnt, 11'(c0 + 4));
    check(rd_data[13] == 1, "R7 still armed", rd_data[13], 1);
    // R4: write without bit 13 keeps the request
    write_word(32'h0000_0010);
    check(rd_data[13] == 1, "R4 not disarmed", rd_data[13], 1);
    trig_in = 0;
    @(negedge clk);
    trig_in = 1;
    @(negedge clk);
    check(coarse_cnt == 0, "R5 cleared", coarse_cnt, 0);
    check(rd_data[13] == 0, "R5 disarmed", rd_data[13], 0);
    @(negedge clk);
    check(coarse_cnt == 1, "R5 resumes", coarse_cnt, 1);
    trig_in = 0;
    // R8: trigger while statistics clear is high
    write_word(32'h0000_2100);
    @(negedge clk); c0 = coarse_cnt; trig_in = 1;
    @(negedge clk);
    check(coarse_cnt == 11'(c0 + 1), "R8 blocked trigger", coarse_cnt, 11'(c0 + 1));
    check(rd_data[13] == 1, "R8 stays armed", rd_data[13], 1);
    trig_in = 0;
    write_word(32'h0);
    trig_in = 1;
    @(negedge clk);
    check(coarse_cnt == 0, "R8 later edge clears", coarse_cnt, 0);
    trig_in = 0;
  endtask

  task automatic t_cal(input int n);
    int gap;
    int guard;
    write_word({4'(n), 28'h0});
    guard = 0;
    while (!cal_hit && guard < 5000) begin @(negedge clk); guard++; end
    @(negedge clk);
    check(!cal_hit, "R10 single cycle", cal_hit, 0);
    gap = 1;
    while (!cal_hit && gap < 5000) begin @(negedge clk); gap++; end
    check(gap == 125 * (1 << n), "R10 period", gap, 125 * (1 << n));
  endtask

  initial begin
    t_reset();
    t_readback();
    t_count();
    t_flags();
    t_arm_and_trigger();
    t_cal(0);
    t_cal(1);
    t_cal(2);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin @(posedge clk); cyc++; end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule